// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Aggregator

The block collects 32 interrupt inputs into one request line for a processor. Each input has its own trigger type, chosen from a pair of bits: rising edge, falling edge, active-high level or active-low level. The inputs are first brought into the clock domain through a two-flop synchroniser. A detector then turns each input into either a one-cycle edge event or a steady level-active flag. Events and active levels are held in a status register. Software clears edge events by writing ones to that register. Only status bits whose enable bit is set take part in the aggregated request.

The request line has two settings of its own. One selects a level or a single-cycle pulse, and the other selects the asserted polarity. An inject register lets software raise any status bit by hand, which is useful for testing the interrupt path. All registers sit behind a simple word-addressed read/write port. Reads return data one cycle after the request.

Top module: `tirq_hub`

## Requirements
- R1: After reset the enable, trigger-kind, trigger-sense, output-mode, output-polarity and inject registers all read 0, and `irq_out` is 0.
- R2: Word addresses are: 0 enable, 1 status, 2 trigger kind, 3 trigger sense, 4 output mode, 5 output polarity, 6 inject. A read issued at one rising edge (`bus_sel`=1, `bus_wr`=0) shows its data on `bus_rdata` after that edge. The output mode and output polarity registers keep only bit 0, and their other bits read 0.
- R3: kind=1 with sense=1 selects a rising-edge trigger, and kind=1 with sense=0 selects a falling-edge trigger. A matching input transition made between clock edges sets the status bit at the third following rising edge.
- R4: kind=0 with sense=1 selects active-high level, and kind=0 with sense=0 (the reset default) selects active-low level. The status bit of a level source follows the qualified input with the same three-edge lag.
- R5: Writing the status register clears every edge-type status bit written with 1. Bits written with 0 are untouched, and an event arriving in the same cycle wins over the clear.
- R6: Writing 1 to the status bit of a level source whose level is still active leaves the bit set.
- R7: Only status bits whose enable bit is 1 contribute to the request. With no enabled bit pending, in level mode with polarity 0, `irq_out` is 0.
- R8: With output mode bit 0 = 0, `irq_out` equals (any enabled status bit set) XOR (output polarity bit 0), registered one edge after the status change.
- R9: With output mode bit 0 = 1, the request (before polarity) is high for exactly one cycle when the enabled-pending set goes from empty to non-empty. It stays low while that set remains non-empty.
- R10: Writing 1 to an inject bit sets the matching status bit at that write edge. The inject register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | N_SRC | Asynchronous interrupt inputs |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
Directed patterns measure the exact edge at which a rising transition reaches the request line. They also show that a falling trigger ignores the opposite transition, and that a one-write clears an edge bit while a zero-write or a clear aimed at a still-active level does not. The pulse-mode sequence tells a first pending source apart from a second one that arrives while the set is already non-empty. Random rounds pick a trigger type for every bit, together with a before/after input pair, an enable mask and a polarity. This separates all four trigger types at once, and it catches swapped kind/sense encodings and masking faults in the aggregated output.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  // Word addresses of the register file
  localparam int unsigned WA_GATE  = 0;
  localparam int unsigned WA_STAT  = 1;
  localparam int unsigned WA_KIND  = 2;
  localparam int unsigned WA_SENSE = 3;
  localparam int unsigned WA_OMODE = 4;
  localparam int unsigned WA_OPOL  = 5;
  localparam int unsigned WA_INJ   = 6;

  // Trigger type as {kind, sense}
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;
endpackage

// File: rtl/tirq_sync.sv
module tirq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tirq_detect.sv
module tirq_detect
  import tirq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] kind,
  input  logic [N-1:0] sense,
  output logic [N-1:0] hit,
  output logic [N-1:0] act,
  output logic [N-1:0] is_edge
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    trig_e t;
    logic  h, a;
    assign t = trig_e'({kind[i], sense[i]});
    always_comb begin
      h = 1'b0;
      a = 1'b0;
      unique case (t)
        TRIG_RISE: h = lvl[i] & ~prev[i];
        TRIG_FALL: h = ~lvl[i] & prev[i];
        TRIG_HIGH: a = lvl[i];
        default:   a = ~lvl[i];
      endcase
    end
    assign hit[i]     = h;
    assign act[i]     = a;
    assign is_edge[i] = kind[i];
  end
endmodule

// File: rtl/tirq_regs.sv
module tirq_regs
  import tirq_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N-1:0]      hit,
  input  logic [N-1:0]      act,
  input  logic [N-1:0]      is_edge,
  output logic [N-1:0]      gate,
  output logic [N-1:0]      kind,
  output logic [N-1:0]      sense,
  output logic              omode,
  output logic              opol,
  output logic [N-1:0]      pend
);
  logic         wr_any, rd_any;
  logic         wr_stat, wr_inj;
  logic [N-1:0] clr_mask, inj_mask, pend_nxt;

  assign wr_any   = bus_sel & bus_wr;
  assign rd_any   = bus_sel & ~bus_wr;
  assign wr_stat  = wr_any && (bus_addr == ADDR_W'(WA_STAT));
  assign wr_inj   = wr_any && (bus_addr == ADDR_W'(WA_INJ));
  assign clr_mask = wr_stat ? bus_wdata[N-1:0] : '0;
  assign inj_mask = wr_inj  ? bus_wdata[N-1:0] : '0;

  for (genvar i = 0; i < N; i++) begin : g_pend
    always_comb begin
      if (is_edge[i]) pend_nxt[i] = (pend[i] & ~clr_mask[i]) | hit[i] | inj_mask[i];
      else            pend_nxt[i] = act[i] | inj_mask[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate  <= '0;
      kind  <= '0;
      sense <= '0;
      omode <= 1'b0;
      opol  <= 1'b0;
      pend  <= '0;
    end else begin
      pend <= pend_nxt;
      if (wr_any) begin
        case (bus_addr)
          ADDR_W'(WA_GATE):  gate  <= bus_wdata[N-1:0];
          ADDR_W'(WA_KIND):  kind  <= bus_wdata[N-1:0];
          ADDR_W'(WA_SENSE): sense <= bus_wdata[N-1:0];
          ADDR_W'(WA_OMODE): omode <= bus_wdata[0];
          ADDR_W'(WA_OPOL):  opol  <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_any) begin
      case (bus_addr)
        ADDR_W'(WA_GATE):  bus_rdata <= 32'(gate);
        ADDR_W'(WA_STAT):  bus_rdata <= 32'(pend);
        ADDR_W'(WA_KIND):  bus_rdata <= 32'(kind);
        ADDR_W'(WA_SENSE): bus_rdata <= 32'(sense);
        ADDR_W'(WA_OMODE): bus_rdata <= {31'b0, omode};
        ADDR_W'(WA_OPOL):  bus_rdata <= {31'b0, opol};
        default:           bus_rdata <= '0;
      endcase
    end
  end

  AST_CLR_EDGE: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> ((pend & $past(is_edge & bus_wdata[N-1:0] & ~hit)) == '0)); // R5
  AST_LVL_TRACK: assert property (@(posedge clk) disable iff (rst)
    !wr_inj |=> (((pend ^ $past(act)) & $past(~is_edge)) == '0)); // R6
  AST_INJ_SET: assert property (@(posedge clk) disable iff (rst)
    wr_inj |=> (($past(bus_wdata[N-1:0]) & ~pend) == '0)); // R10
  AST_INJ_RDZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_any && bus_addr == ADDR_W'(WA_INJ)) |=> (bus_rdata == '0)); // R10
endmodule

// File: rtl/tirq_out.sv
module tirq_out #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] gate,
  input  logic         omode,
  input  logic         opol,
  output logic         irq_out
);
  logic any, any_q, req;

  assign any = |(pend & gate);
  assign req = omode ? (any & ~any_q) : any;

  always_ff @(posedge clk) begin
    if (rst) begin
      any_q   <= 1'b0;
      irq_out <= 1'b0;
    end else begin
      any_q   <= any;
      irq_out <= req ^ opol;
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    (omode && $stable(opol) && (irq_out != opol)) |=> (irq_out == $past(opol))); // R9
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (((pend & gate) == '0) && !omode && !opol) |=> !irq_out); // R7
endmodule

// File: rtl/tirq_hub.sv
module tirq_hub #(
  parameter int N_SRC       = 32,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_src,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  logic [N_SRC-1:0] lvl, hit, act, is_edge;
  logic [N_SRC-1:0] gate, kind, sense, pend;
  logic             omode, opol;

  tirq_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_src), .q(lvl)
  );

  tirq_detect #(.N(N_SRC)) u_det (
    .clk(clk), .rst(rst), .lvl(lvl), .kind(kind), .sense(sense),
    .hit(hit), .act(act), .is_edge(is_edge)
  );

  tirq_regs #(.N(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hit(hit), .act(act), .is_edge(is_edge), .gate(gate), .kind(kind),
    .sense(sense), .omode(omode), .opol(opol), .pend(pend)
  );

  tirq_out #(.N(N_SRC)) u_out (
    .clk(clk), .rst(rst), .pend(pend), .gate(gate), .omode(omode),
    .opol(opol), .irq_out(irq_out)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !irq_out); // R1
endmodule

// File: tb/sim_tirq_hub.sv
module sim_tirq_hub;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tirq_hub u0 (
    .clk(clk), .rst(rst), .irq_src(src), .bus_sel(sel), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = AW'(a); wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic rreg(input int a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = AW'(a);
    @(negedge clk); d = rdata; sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_stat(input logic [31:0] k, s, a, b);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      case ({k[i], s[i]})
        2'b11:   r[i] = ~a[i] & b[i];
        2'b10:   r[i] = a[i] & ~b[i];
        2'b01:   r[i] = b[i];
        default: r[i] = ~b[i];
      endcase
    end
    return r;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int highs;
    void'($urandom(32'h5eed_0101));
    idle(4);
    rst = 0;

    // R1 reset state
    chk("R1 irq_out", 32'(irq), 0);
    rreg(0, d); chk("R1 enable", d, 0);
    rreg(2, d); chk("R1 kind", d, 0);
    rreg(3, d); chk("R1 sense", d, 0);
    rreg(4, d); chk("R1 omode", d, 0);
    rreg(5, d); chk("R1 opol", d, 0);
    rreg(6, d); chk("R1 inject", d, 0);
    // R4 default active-low with inputs low: all pending
    rreg(1, d); chk("R4 default low level", d, 32'hFFFF_FFFF);

    // R2 map and readback
    wreg(0, 32'h0000_0000);
    wreg(2, 32'hA5A5_0F0F); rreg(2, d); chk("R2 kind rb", d, 32'hA5A5_0F0F);
    wreg(3, 32'h3C3C_F00F); rreg(3, d); chk("R2 sense rb", d, 32'h3C3C_F00F);
    wreg(4, 32'hFFFF_FFFE); rreg(4, d); chk("R2 omode bit0", d, 0);
    wreg(5, 32'hFFFF_FFFF); rreg(5, d); chk("R2 opol bit0", d, 1);
    wreg(5, 0); wreg(4, 0);

    // R3 rising-edge latency to irq_out (R8 level output)
    wreg(2, 32'h0000_000B); wreg(3, 32'h0000_0009); // b0 rise, b1 fall, b3 rise
    wreg(1, 32'hFFFF_FFFF);
    wreg(0, 32'h0000_0001);
    idle(3);
    chk("R7 masked idle", 32'(irq), 0);
    @(negedge clk); src[0] = 1'b1;
    idle(3); chk("R3 no early status", 32'(irq), 0);
    idle(1); chk("R3 R8 rise reaches irq", 32'(irq), 1);
    wreg(5, 1); idle(1); chk("R8 polarity inverts", 32'(irq), 0);
    wreg(5, 0);
    wreg(0, 0); idle(1); chk("R7 enable cleared", 32'(irq), 0);

    // R3 falling trigger on bit 1
    @(negedge clk); src[1] = 1'b1; idle(5);
    rreg(1, d); chk("R3 fall ignores rise", 32'(d[1]), 0);
    @(negedge clk); src[1] = 1'b0; idle(5);
    rreg(1, d); chk("R3 fall latched", 32'(d[1]), 1);

    // R5 write-one-clear on bit 3
    @(negedge clk); src[3] = 1'b1; idle(5);
    wreg(1, 0); rreg(1, d); chk("R5 zero write keeps", 32'(d[3]), 1);
    wreg(1, 32'h0000_0008); rreg(1, d); chk("R5 one write clears", 32'(d[3]), 0);
    chk("R5 other edge bit kept", 32'(d[1]), 1);

    // R6 clear on active level
    wreg(2, 32'h0000_000B); wreg(3, 32'h0000_0019); // b4 active-high
    @(negedge clk); src[4] = 1'b1; idle(5);
    wreg(1, 32'h0000_0010); idle(2);
    rreg(1, d); chk("R6 level stays set", 32'(d[4]), 1);
    @(negedge clk); src[4] = 1'b0; idle(5);
    rreg(1, d); chk("R4 high level follows", 32'(d[4]), 0);

    // R10 inject
    wreg(1, 32'hFFFF_FFFF);
    wreg(6, 32'h0000_0008);
    rreg(1, d); chk("R10 inject sets", 32'(d[3]), 1);
    rreg(6, d); chk("R10 inject reads 0", d, 0);

    // R9 pulse mode
    src = '0; idle(5);
    wreg(2, 32'h0000_0003); wreg(3, 32'h0000_0003);
    wreg(1, 32'hFFFF_FFFF);
    wreg(0, 32'h0000_0003);
    wreg(4, 1); idle(2);
    chk("R9 idle", 32'(irq), 0);
    @(negedge clk); src[0] = 1'b1;
    idle(3); chk("R9 before pulse", 32'(irq), 0);
    idle(1); chk("R9 pulse high", 32'(irq), 1);
    idle(1); chk("R9 pulse one cycle", 32'(irq), 0);
    @(negedge clk); src[1] = 1'b1;
    highs = 0;
    for (int c = 0; c < 8; c++) begin @(negedge clk); if (irq) highs++; end
    chk("R9 no pulse while non-empty", 32'(highs), 0);
    wreg(1, 32'hFFFF_FFFF); idle(2);
    @(negedge clk); src[1] = 1'b0; idle(4);
    @(negedge clk); src[1] = 1'b1;
    highs = 0;
    for (int c = 0; c < 8; c++) begin @(negedge clk); if (irq) highs++; end
    chk("R9 re-arm single pulse", 32'(highs), 1);
    wreg(4, 0);

    // Random rounds: R3 R4 R7 R8
    for (int r = 0; r < 60; r++) begin
      logic [31:0] k, s, a, b, en, e;
      logic pol;
      k = $urandom; s = $urandom; a = $urandom; b = $urandom; en = $urandom;
      pol = 1'($urandom);
      if (r % 4 == 0) en = 32'(1) << ($urandom % 32);
      wreg(0, 0);
      wreg(2, k); wreg(3, s);
      @(negedge clk); src = a; idle(6);
      wreg(1, 32'hFFFF_FFFF);
      @(negedge clk); src = b; idle(6);
      e = exp_stat(k, s, a, b);
      rreg(1, d); chk("R3 R4 random status", d, e);
      wreg(0, en); wreg(5, 32'(pol)); idle(1);
      chk("R7 R8 random irq", 32'(irq), 32'((|(e & en)) ^ pol));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule